// File: doc/BRIEF.md
# Stack-Position Register Alias Table

This block sits in the rename stage of a processor whose floating-point registers are addressed as a stack. It maps the eight stack-relative names ST(0) to ST(7) onto eight fixed physical registers. It does this with a 3-bit top pointer and a name table that is always a permutation of the physical indices. No data is ever moved. An exchange swaps two table entries. A push or a pop only moves the top pointer and marks a physical register as live or free.

Each cycle, up to two decoded operations enter in program order on slot 0 and slot 1. The block returns the physical register behind ST(0) and behind ST(i) for each slot in the same cycle. Slot 1 resolves against the state that slot 0 has just produced, so a push or a double pop can pair with an exchange without a stall. An occupancy vector, indexed by physical register, drives an overflow flag and an underflow flag for each slot.

A checkpoint of the whole state can be captured at any cycle. A flush restores that checkpoint in one cycle to recover from misspeculation.

Top module: `stack_alias_table`

## Requirements
- R1: After reset, the top pointer is 0, the table holds the identity mapping (position k maps to physical k), and all eight physical registers are marked empty.
- R2: ST(i) of a slot resolves combinationally, in the same cycle, to table[(top + i) mod 8]. The state seen by a slot is the registered state, or for slot 1 the state left by slot 0.
- R3: An exchange (kind code 4) swaps the table entries for ST(0) and ST(i) in the next state. The top pointer and the occupancy are left unchanged. The reported indices are the ones before the swap.
- R4: A push (kind code 1) decrements top modulo 8 and marks the new ST(0) register as live. It reports that register as ST(0), and reports ST(i) as resolved before the push.
- R5: A pop (kind code 2) frees ST(0) and increments top by one. A double pop (kind code 3) frees ST(0) and ST(1) and increments top by two. Both report their indices before the pop.
- R6: Slot 1 sees the table, top and occupancy as updated by slot 0 in the same cycle.
- R7: A push whose destination register is already live raises that slot's overflow flag. The mapping and top are still updated.
- R8: A pop, double pop or exchange that reads an empty register raises that slot's underflow flag. The state is still updated.
- R9: With the save input high and no flush, the checkpoint captures the state after this cycle's operations. With flush high, the next state is the checkpoint, the slot operations are ignored, and every flag is low.
- R10: A slot whose valid is low, or whose kind is 0 or an unused code (5 to 7), changes no state and raises no flag. It still reports its resolved indices.
- R11: The table is a permutation of the eight physical indices at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Restore the checkpoint and ignore this cycle's operations |
| ckpt_save | input | 1 | Capture the post-operation state as the checkpoint |
| op_valid | input | NSLOT | Per-slot operation valid |
| op_kind | input | NSLOT x 3 | Per-slot kind: 0 none, 1 push, 2 pop, 3 double pop, 4 exchange |
| op_idx | input | NSLOT x 3 | Per-slot stack operand index i |
| st0_phys | output | NSLOT x 3 | Physical register for ST(0) of each slot |
| sti_phys | output | NSLOT x 3 | Physical register for ST(i) of each slot |
| ovf | output | NSLOT | Per-slot stack overflow |
| unf | output | NSLOT | Per-slot stack underflow |

## Verification
Resolved indices and both flags are combinational, so they are due in the cycle the operation is presented. The bench drives at the falling edge and samples two time units later, well before the rising edge. Updates to the table, top pointer, occupancy and checkpoint take effect one rising edge later. The bench observes them by presenting a slot 0 operation with kind 0 in the following cycle and reading its ST(i) output. Operations paired in one cycle are checked in that same cycle, and their combined effect is checked on the next.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int NPOS = 8;                 // stack positions, power of two
    localparam int IDXW = $clog2(NPOS);

    typedef logic [IDXW-1:0] pidx_t;

    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_PUSH = 3'd1;
    localparam logic [2:0] K_POP  = 3'd2;
    localparam logic [2:0] K_DPOP = 3'd3;
    localparam logic [2:0] K_XCH  = 3'd4;

    typedef struct packed {
        pidx_t [NPOS-1:0] map;   // stack slot -> physical register
        pidx_t            top;
        logic  [NPOS-1:0] occ;   // live flag per physical register
    } sat_state_t;

    function automatic sat_state_t sat_boot_state();
        sat_state_t s;
        for (int k = 0; k < NPOS; k++) begin
            s.map[k] = pidx_t'(k);
        end
        s.top = '0;
        s.occ = '0;
        return s;
    endfunction
endpackage

// File: rtl/sat_slot.sv
module sat_slot
    import sat_pkg::*;
(
    input  sat_state_t cur,
    input  logic       valid,
    input  logic       mute,
    input  logic [2:0] kind,
    input  pidx_t      sel,
    output sat_state_t nxt,
    output pidx_t      st0,
    output pidx_t      sti,
    output logic       ovf,
    output logic       unf
);
    localparam pidx_t ONE = pidx_t'(1);
    localparam pidx_t TWO = pidx_t'(2);

    pidx_t pos_i;
    pidx_t pos_1;
    pidx_t pos_dn;
    pidx_t phys_1;
    pidx_t phys_dn;

    always_comb begin
        pos_i   = cur.top + sel;
        pos_1   = cur.top + ONE;
        pos_dn  = cur.top - ONE;
        phys_1  = cur.map[pos_1];
        phys_dn = cur.map[pos_dn];

        nxt = cur;
        st0 = cur.map[cur.top];
        sti = cur.map[pos_i];
        ovf = 1'b0;
        unf = 1'b0;

        if (valid && !mute) begin
            case (kind)
                K_PUSH: begin
                    st0               = phys_dn;
                    ovf               = cur.occ[phys_dn];
                    nxt.top           = pos_dn;
                    nxt.occ[phys_dn]  = 1'b1;
                end
                K_POP: begin
                    unf                       = !cur.occ[cur.map[cur.top]];
                    nxt.occ[cur.map[cur.top]] = 1'b0;
                    nxt.top                   = pos_1;
                end
                K_DPOP: begin
                    unf = !cur.occ[cur.map[cur.top]] || !cur.occ[phys_1];
                    nxt.occ[cur.map[cur.top]] = 1'b0;
                    nxt.occ[phys_1]           = 1'b0;
                    nxt.top                   = cur.top + TWO;
                end
                K_XCH: begin
                    unf = !cur.occ[cur.map[cur.top]] || !cur.occ[cur.map[pos_i]];
                    nxt.map[cur.top] = cur.map[pos_i];
                    nxt.map[pos_i]   = cur.map[cur.top];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sat_ckpt.sv
module sat_ckpt
    import sat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       save,
    input  sat_state_t snap,
    output sat_state_t held
);
    sat_state_t held_d;
    sat_state_t held_q;

    always_comb begin
        held_d = held_q;
        if (save) held_d = snap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= sat_boot_state();
        else        held_q <= held_d;
    end

    assign held = held_q;
endmodule

// File: rtl/stack_alias_table.sv
module stack_alias_table
    import sat_pkg::*;
#(
    parameter int NSLOT = 2
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       ckpt_save,
    input  logic [NSLOT-1:0]           op_valid,
    input  logic [NSLOT-1:0][2:0]      op_kind,
    input  logic [NSLOT-1:0][IDXW-1:0] op_idx,
    output logic [NSLOT-1:0][IDXW-1:0] st0_phys,
    output logic [NSLOT-1:0][IDXW-1:0] sti_phys,
    output logic [NSLOT-1:0]           ovf,
    output logic [NSLOT-1:0]           unf
);
    sat_state_t state_d;
    sat_state_t state_q;
    sat_state_t ckpt_q;
    sat_state_t chain [NSLOT+1];

    assign chain[0] = state_q;

    // In-order slot chain: slot g+1 resolves against slot g's result
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        sat_slot u_slot (
            .cur   (chain[g]),
            .valid (op_valid[g]),
            .mute  (flush),
            .kind  (op_kind[g]),
            .sel   (op_idx[g]),
            .nxt   (chain[g+1]),
            .st0   (st0_phys[g]),
            .sti   (sti_phys[g]),
            .ovf   (ovf[g]),
            .unf   (unf[g])
        );
    end

    sat_ckpt u_ckpt (
        .clk   (clk),
        .rst_n (rst_n),
        .save  (ckpt_save && !flush),
        .snap  (chain[NSLOT]),
        .held  (ckpt_q)
    );

    always_comb begin
        state_d = chain[NSLOT];
        if (flush) state_d = ckpt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= sat_boot_state();
        else        state_q <= state_d;
    end
endmodule

// File: rtl/sat_checker.sv
module sat_checker
    import sat_pkg::*;
#(
    parameter int NSLOT = 2
)(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic [NSLOT-1:0]      op_valid,
    input logic [NSLOT-1:0][2:0] op_kind,
    input logic [NSLOT-1:0]      ovf,
    input logic [NSLOT-1:0]      unf,
    input sat_state_t            state_q,
    input sat_state_t            ckpt_q
);
    logic [NPOS-1:0] covered;
    logic            only_s0;

    always_comb begin
        covered = '0;
        for (int p = 0; p < NPOS; p++) covered[state_q.map[p]] = 1'b1;
        only_s0 = op_valid[0] && !(|op_valid[NSLOT-1:1]);
    end

    p_boot_state_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q.top == '0 && state_q.occ == '0));

    p_permutation_r11: assert property (@(posedge clk) disable iff (!rst_n)
        &covered);

    p_flush_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == $past(ckpt_q)));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (ovf == '0 && unf == '0));

    p_xch_keeps_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (only_s0 && op_kind[0] == K_XCH && !flush)
        |=> (state_q.top == $past(state_q.top) && state_q.occ == $past(state_q.occ)));

    p_push_moves_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (only_s0 && op_kind[0] == K_PUSH && !flush)
        |=> (state_q.top == $past(state_q.top) - pidx_t'(1)));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid == '0 && !flush) |=> $stable(state_q));
endmodule

bind stack_alias_table sat_checker #(.NSLOT(NSLOT)) u_sat_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .ovf      (ovf),
    .unf      (unf),
    .state_q  (state_q),
    .ckpt_q   (ckpt_q)
);

// File: tb/stack_alias_table_bench.sv
module stack_alias_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_NONE = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2,
                           C_DPOP = 3'd3, C_XCH = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic ckpt_save = 1'b0;
    logic [1:0]      op_valid = '0;
    logic [1:0][2:0] op_kind = '0;
    logic [1:0][2:0] op_idx = '0;
    logic [1:0][2:0] st0_phys;
    logic [1:0][2:0] sti_phys;
    logic [1:0]      ovf;
    logic [1:0]      unf;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_alias_table #(.NSLOT(2)) u_stack_alias_table (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ckpt_save(ckpt_save),
        .op_valid(op_valid), .op_kind(op_kind), .op_idx(op_idx),
        .st0_phys(st0_phys), .sti_phys(sti_phys), .ovf(ovf), .unf(unf)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at falling edge; outputs are combinational, sample 2 units later
    task automatic put(logic v0, logic [2:0] k0, int i0,
                       logic v1, logic [2:0] k1, int i1,
                       logic fl = 1'b0, logic sv = 1'b0);
        @(negedge clk);
        op_valid  = {v1, v0};
        op_kind   = {k1, k0};
        op_idx    = {3'(i1), 3'(i0)};
        flush     = fl;
        ckpt_save = sv;
        #2;
    endtask

    task automatic peek(int i, output int p);
        put(1'b1, C_NONE, i, 1'b0, C_NONE, 0);
        p = int'(sti_phys[0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = '0; flush = 1'b0; ckpt_save = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        int p;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            peek(k, p);
            chk("R1", "identity map", p, k);
        end
        chk("R10", "none kind ovf", int'(ovf[0]), 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R1", "pop at reset st0", int'(st0_phys[0]), 0);
        chk("R8", "pop of empty unf", int'(unf[0]), 1);
    endtask

    task automatic t_push();
        int p;
        do_reset();
        put(1'b1, C_PUSH, 3, 1'b0, C_NONE, 0);
        chk("R4", "push dest", int'(st0_phys[0]), 7);
        chk("R4", "push src pre-push", int'(sti_phys[0]), 3);
        chk("R4", "push ovf", int'(ovf[0]), 0);
        peek(0, p); chk("R2", "ST0 after push", p, 7);
        peek(1, p); chk("R2", "ST1 after push", p, 0);
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        chk("R4", "second push dest", int'(st0_phys[0]), 6);
        chk("R4", "second push src", int'(sti_phys[0]), 7);
    endtask

    task automatic t_overflow();
        int p;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
            chk("R7", "fill no ovf", int'(ovf[0]), 0);
            chk("R4", "fill dest", int'(st0_phys[0]), 7 - k);
        end
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        chk("R7", "ninth push ovf", int'(ovf[0]), 1);
        chk("R7", "ninth push dest", int'(st0_phys[0]), 7);
        peek(0, p); chk("R7", "top moved despite ovf", p, 7);
    endtask

    task automatic t_exchange();
        int p;
        do_reset();
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_XCH, 1, 1'b0, C_NONE, 0);
        chk("R3", "xch st0 pre-swap", int'(st0_phys[0]), 6);
        chk("R3", "xch sti pre-swap", int'(sti_phys[0]), 7);
        chk("R3", "xch unf", int'(unf[0]), 0);
        peek(0, p); chk("R3", "ST0 swapped", p, 7);
        peek(1, p); chk("R3", "ST1 swapped", p, 6);
        peek(2, p); chk("R3", "top unchanged", p, 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R3", "occupancy kept, pop st0", int'(st0_phys[0]), 7);
        chk("R3", "occupancy kept, pop unf", int'(unf[0]), 0);
    endtask

    task automatic t_pop();
        int p;
        do_reset();
        for (int k = 0; k < 3; k++) put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R5", "pop st0", int'(st0_phys[0]), 5);
        chk("R5", "pop unf", int'(unf[0]), 0);
        put(1'b1, C_DPOP, 1, 1'b0, C_NONE, 0);
        chk("R5", "dpop st0", int'(st0_phys[0]), 6);
        chk("R5", "dpop st1", int'(sti_phys[0]), 7);
        chk("R5", "dpop unf", int'(unf[0]), 0);
        peek(0, p); chk("R5", "top after dpop", p, 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R8", "pop after drain unf", int'(unf[0]), 1);
    endtask

    task automatic t_dual();
        int p;
        do_reset();
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_PUSH, 0, 1'b1, C_XCH, 2);
        chk("R6", "slot0 push dest", int'(st0_phys[0]), 5);
        chk("R6", "slot0 push src", int'(sti_phys[0]), 6);
        chk("R6", "slot1 sees new ST0", int'(st0_phys[1]), 5);
        chk("R6", "slot1 sees new ST2", int'(sti_phys[1]), 7);
        chk("R6", "slot1 unf", int'(unf[1]), 0);
        peek(0, p); chk("R6", "ST0 after pair", p, 7);
        peek(1, p); chk("R6", "ST1 after pair", p, 6);
        peek(2, p); chk("R6", "ST2 after pair", p, 5);
        put(1'b1, C_DPOP, 1, 1'b1, C_XCH, 1);
        chk("R6", "dpop st0", int'(st0_phys[0]), 7);
        chk("R6", "dpop st1", int'(sti_phys[0]), 6);
        chk("R6", "dpop unf", int'(unf[0]), 0);
        chk("R6", "xch after dpop st0", int'(st0_phys[1]), 5);
        chk("R6", "xch after dpop sti", int'(sti_phys[1]), 0);
        chk("R8", "xch after dpop unf", int'(unf[1]), 1);
    endtask

    task automatic t_ignored();
        int p;
        do_reset();
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_NONE, 3, 1'b0, C_PUSH, 0);
        chk("R10", "none flags", int'(ovf[0] | unf[0]), 0);
        chk("R10", "invalid slot flags", int'(ovf[1] | unf[1]), 0);
        chk("R10", "none still resolves", int'(sti_phys[0]), 2);
        put(1'b1, 3'd7, 1, 1'b1, 3'd5, 2);
        chk("R10", "unused codes flags", int'(ovf | unf), 0);
        peek(0, p); chk("R10", "top unchanged", p, 7);
        peek(1, p); chk("R10", "map unchanged", p, 0);
    endtask

    task automatic t_flush();
        int p;
        do_reset();
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0);
        put(1'b1, C_PUSH, 0, 1'b0, C_NONE, 0, 1'b0, 1'b1);
        put(1'b1, C_PUSH, 0, 1'b1, C_XCH, 1);
        put(1'b1, C_POP, 0, 1'b1, C_POP, 0);
        put(1'b1, C_POP, 0, 1'b1, C_POP, 0, 1'b1, 1'b1);
        chk("R9", "flags low in flush", int'(ovf | unf), 0);
        peek(0, p); chk("R9", "restored ST0", p, 6);
        peek(1, p); chk("R9", "restored ST1", p, 7);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R9", "restored occ pop1", int'(unf[0]), 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R9", "restored occ pop2", int'(unf[0]), 0);
        put(1'b1, C_POP, 0, 1'b0, C_NONE, 0);
        chk("R9", "restored occ pop3", int'(unf[0]), 1);
    endtask

    task automatic t_perm();
        int m[8];
        int p;
        int t;
        bit seen[8];
        do_reset();
        for (int k = 0; k < 8; k++) m[k] = k;
        t = 0;
        for (int k = 0; k < 20; k++) begin
            int i;
            int a;
            i = (k * 3 + 1) % 8;
            put(1'b1, C_XCH, i, 1'b0, C_NONE, 0);
            chk("R2", "xch walk st0", int'(st0_phys[0]), m[t]);
            chk("R3", "xch walk sti", int'(sti_phys[0]), m[(t + i) % 8]);
            a = m[t]; m[t] = m[(t + i) % 8]; m[(t + i) % 8] = a;
        end
        for (int k = 0; k < 8; k++) seen[k] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            peek(k, p);
            chk("R11", "final map", p, m[k]);
            seen[p] = 1'b1;
        end
        for (int k = 0; k < 8; k++) chk("R11", "each phys once", int'(seen[k]), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_push();
        t_overflow();
        t_exchange();
        t_pop();
        t_dual();
        t_ignored();
        t_flush();
        t_perm();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule